// File: doc/BRIEF.md
# Receive Byte Buffer with Software Flow Control

This block sits between a UART receiver and the command parser that consumes its bytes. Each byte the receiver delivers is stored in a small first-in first-out buffer. The parser reads bytes from the head of that buffer through a pop strobe. The buffer has room for 128 bytes by default. If a byte arrives when no slot is free, the byte is discarded and a sticky overflow indication is raised.

To keep the sender from overrunning the buffer, the block watches its own fill level and uses hysteresis to decide when to ask for one pause character (0x13) or one resume character (0x11). It presents that character on a request/acknowledge interface that leads to the UART transmitter. The incoming stream is binary command traffic, so those two values are stored like any other data when they arrive. They never affect the flow control.

An inactivity timer restarts on every received byte. When it runs out, it emits a single-cycle pulse that tells the parser to drop any partly decoded command and resynchronise. The default timeout is 250,000,000 cycles, which is five seconds at 50 MHz. The asynchronous active-low reset is released synchronously inside the block, two clock edges after it deasserts.

Top module: `rx_flow_buffer`

## Requirements
- R1: Bytes leave in arrival order. `head_data` shows the oldest stored byte without a read delay. `empty` is 1 exactly when no byte is stored. Up to DEPTH (default 128) bytes can be held.
- R2: Received values 0x11 and 0x13 are stored and delivered as ordinary data. They never cause or cancel a flow-control request.
- R3: In the cycle after the fill level first reaches 3/4 of DEPTH (96 by default), `tx_req` rises with `tx_char` = 0x13.
- R4: Once 0x13 has been acknowledged, `tx_req` rises with `tx_char` = 0x11 one cycle after the fill level falls below DEPTH/4 (32). A level of exactly 32 does not trigger it.
- R5: Each threshold crossing produces exactly one request. While the sender is paused, no further 0x13 is requested, however high the level climbs.
- R6: `tx_req` and `tx_char` stay unchanged until a cycle in which `tx_ack` is high. The request drops in the following cycle.
- R7: A byte that arrives while the buffer is full and no pop occurs is dropped, and `ovf_sticky` becomes 1 in the next cycle.
- R8: `ovf_sticky` stays 1 until `ovf_clear` is pulsed. If a new drop happens in the same cycle as `ovf_clear`, the flag stays set.
- R9: A push and a pop in the same cycle both succeed and leave the fill level unchanged. This holds even when the buffer is full.
- R10: A pop while `empty` is 1 is ignored and leaves the buffer empty.
- R11: `parser_reset` is high for exactly one cycle, IDLE_CYCLES clock edges after the last edge at which `rx_valid` was sampled high. It does not repeat until another byte arrives.
- R12: Every received byte restarts the inactivity count. Bytes that arrive fewer than IDLE_CYCLES cycles apart never produce `parser_reset`.
- R13: After reset the buffer is empty, `ovf_sticky`, `tx_req` and `parser_reset` are 0, and the sender is considered running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | DATA_W | Received byte |
| pop | input | 1 | Consumer removes the head byte |
| head_data | output | DATA_W | Oldest stored byte |
| empty | output | 1 | Buffer holds no byte |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| ovf_sticky | output | 1 | A byte was dropped since the last clear |
| tx_req | output | 1 | Flow-control character waiting to be sent |
| tx_char | output | 8 | Character to send (0x13 pause, 0x11 resume) |
| tx_ack | input | 1 | Transmitter has taken `tx_char` |
| parser_reset | output | 1 | One-cycle inactivity timeout pulse |

## Verification
The assertions take for granted that `rx_valid` is a one-cycle-per-byte strobe and that `tx_ack` is only raised while `tx_req` is high. They also assume IDLE_CYCLES is at least 2, so that a byte and a timeout pulse cannot share neighbouring cycles. The stimulus keeps to these assumptions. The acknowledging responder only answers a request it has watched for three cycles and lowers `tx_ack` right after. Pushes and pops are always whole-cycle strobes driven on the falling edge, and the inactivity tests use a short timeout of 300 cycles.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam logic [7:0] PAUSE_CHAR  = 8'h13;
  localparam logic [7:0] RESUME_CHAR = 8'h11;

  typedef enum logic [1:0] {
    FC_RUNNING   = 2'd0,
    FC_ASK_PAUSE = 2'd1,
    FC_PAUSED    = 2'd2,
    FC_ASK_RESUME = 2'd3
  } fc_state_t;
endpackage

// File: rtl/rfb_rst_sync.sv
module rfb_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rfb_fifo.sv
module rfb_fifo #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  input  logic              ovf_clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic              ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DATA_W-1:0] store_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]     level_q, level_d;
  logic              ovf_q, ovf_d;
  logic              wr_en, rd_en, is_full, is_empty;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    if (p == AW'(DEPTH-1)) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    is_empty = (level_q == '0);
    is_full  = (level_q == CW'(DEPTH));
    rd_en    = rd_req_i && !is_empty;
    wr_en    = wr_valid_i && (!is_full || rd_en);

    wr_ptr_d = wr_en ? ptr_step(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = rd_en ? ptr_step(rd_ptr_q) : rd_ptr_q;

    unique case ({wr_en, rd_en})
      2'b10:   level_d = level_q + 1'b1;
      2'b01:   level_d = level_q - 1'b1;
      default: level_d = level_q;
    endcase

    if (wr_valid_i && !wr_en) ovf_d = 1'b1;
    else if (ovf_clr_i)       ovf_d = 1'b0;
    else                      ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_ptr_q] <= wr_data_i;
  end

  assign rd_data_o = store_q[rd_ptr_q];
  assign empty_o   = is_empty;
  assign level_o   = level_q;
  assign ovf_o     = ovf_q;

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= CW'(DEPTH));

  a_r7_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && is_full && !rd_req_i) |=> (ovf_q && level_q == CW'(DEPTH)));

  a_r9_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> (level_q == $past(level_q)));

  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && rd_req_i && !wr_valid_i) |=> (level_q == '0));
endmodule

// File: rtl/rfb_flow.sv
module rfb_flow
  import rfb_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int HIGH  = 96,
  parameter int LOW   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(DEPTH+1)-1:0] level_i,
  input  logic                       ack_i,
  output logic                       req_o,
  output logic [7:0]                 char_o
);
  localparam int CW = $clog2(DEPTH+1);

  fc_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FC_RUNNING:    if (level_i >= CW'(HIGH)) state_d = FC_ASK_PAUSE;
      FC_ASK_PAUSE:  if (ack_i)                state_d = FC_PAUSED;
      FC_PAUSED:     if (level_i < CW'(LOW))   state_d = FC_ASK_RESUME;
      FC_ASK_RESUME: if (ack_i)                state_d = FC_RUNNING;
      default:                                 state_d = FC_RUNNING;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FC_RUNNING;
    else        state_q <= state_d;
  end

  assign req_o  = (state_q == FC_ASK_PAUSE) || (state_q == FC_ASK_RESUME);
  assign char_o = (state_q == FC_ASK_RESUME) ? RESUME_CHAR : PAUSE_CHAR;

  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(char_o)));

  a_r6_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_i) |=> !req_o);

  a_r3_pause_trip: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_o) && char_o == PAUSE_CHAR) |-> ($past(level_i) >= CW'(HIGH)));

  a_r4_resume_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_o) && char_o == RESUME_CHAR) |-> ($past(level_i) < CW'(LOW)));
endmodule

// File: rtl/rfb_idle.sv
module rfb_idle #(
  parameter int IDLE_CYCLES = 250_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activity_i,
  output logic timeout_o
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fired_q, fired_d;
  logic          pulse_q, pulse_d;

  always_comb begin
    cnt_d   = cnt_q;
    fired_d = fired_q;
    pulse_d = 1'b0;
    if (activity_i) begin
      cnt_d   = '0;
      fired_d = 1'b0;
    end else if (!fired_q) begin
      if (cnt_q == CW'(IDLE_CYCLES - 1)) begin
        pulse_d = 1'b1;
        fired_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
      pulse_q <= pulse_d;
    end
  end

  assign timeout_o = pulse_q;

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  a_r12_restart: assert property (@(posedge clk) disable iff (!rst_n)
    activity_i |=> !timeout_o);
endmodule

// File: rtl/rx_flow_buffer.sv
module rx_flow_buffer #(
  parameter int DEPTH       = 128,
  parameter int DATA_W      = 8,
  parameter int IDLE_CYCLES = 250_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              empty,
  input  logic              ovf_clear,
  output logic              ovf_sticky,
  output logic              tx_req,
  output logic [7:0]        tx_char,
  input  logic              tx_ack,
  output logic              parser_reset
);
  localparam int CW   = $clog2(DEPTH+1);
  localparam int HIGH = (DEPTH * 3) / 4;
  localparam int LOW  = DEPTH / 4;

  logic          rst_n_int;
  logic [CW-1:0] fill;

  rfb_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  rfb_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_valid_i (rx_valid),
    .wr_data_i  (rx_data),
    .rd_req_i   (pop),
    .ovf_clr_i  (ovf_clear),
    .rd_data_o  (head_data),
    .empty_o    (empty),
    .level_o    (fill),
    .ovf_o      (ovf_sticky)
  );

  rfb_flow #(.DEPTH(DEPTH), .HIGH(HIGH), .LOW(LOW)) u_flow (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .level_i (fill),
    .ack_i   (tx_ack),
    .req_o   (tx_req),
    .char_o  (tx_char)
  );

  rfb_idle #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .activity_i (rx_valid),
    .timeout_o  (parser_reset)
  );

  a_r13_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(rst_n_int) |-> (empty && !tx_req && !ovf_sticky));
endmodule

// File: tb/test_rx_flow_buffer.sv
module test_rx_flow_buffer;
  localparam int DEPTH = 128;
  localparam int IDLE  = 300;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, pop, ovf_clear, tx_ack;
  logic [7:0] rx_data, head_data, tx_char;
  logic       empty, ovf_sticky, tx_req, parser_reset;

  int   n_cmp = 0;
  int   n_bad = 0;
  int   mcount = 0;
  int   hold = 0;
  logic [7:0] held_char;
  logic [7:0] exp_q [$];
  logic [7:0] got_tx [$];

  always #5 clk = ~clk;

  rx_flow_buffer #(.DEPTH(DEPTH), .DATA_W(8), .IDLE_CYCLES(IDLE)) i_rx_flow_buffer (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .pop(pop), .head_data(head_data), .empty(empty),
    .ovf_clear(ovf_clear), .ovf_sticky(ovf_sticky),
    .tx_req(tx_req), .tx_char(tx_char), .tx_ack(tx_ack),
    .parser_reset(parser_reset)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares every accepted pop with the queue head
  always begin
    @(negedge clk);
    #1;
    if (rst_n && pop && !empty) begin
      if (exp_q.size() == 0) check(1'b0, "R1 pop with empty model", head_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(head_data == e, "R1 order", head_data, e);
      end
    end
  end

  // transmit responder: acknowledges after watching the request 3 cycles
  always @(negedge clk) begin
    if (tx_ack) tx_ack = 1'b0;
    else if (rst_n && tx_req) begin
      if (hold == 0) held_char = tx_char;
      else if (tx_char != held_char) check(1'b0, "R6 char stable", tx_char, held_char);
      if (hold == 2) begin
        tx_ack = 1'b1;
        got_tx.push_back(tx_char);
        check(tx_char == held_char, "R6 held until ack", tx_char, held_char);
        hold = 0;
      end else hold++;
    end
  end

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    if (mcount < DEPTH) begin exp_q.push_back(b); mcount++; end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pop_one();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    if (mcount > 0) mcount--;
  endtask

  task automatic push_pop(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b; pop = 1'b1;
    exp_q.push_back(b);
    if (mcount == 0) mcount++;
    @(negedge clk);
    rx_valid = 1'b0; pop = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n0, first, pulses;
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; pop = 1'b0;
    ovf_clear = 1'b0; tx_ack = 1'b0;
    idle_cycles(3);
    rst_n = 1'b1;
    idle_cycles(3);

    // R13 reset state
    check(empty == 1'b1, "R13 empty", empty, 1);
    check(tx_req == 1'b0, "R13 tx_req", tx_req, 0);
    check(ovf_sticky == 1'b0, "R13 ovf", ovf_sticky, 0);
    check(parser_reset == 1'b0, "R13 parser_reset", parser_reset, 0);

    // R10 pop on empty ignored
    pop_one();
    check(empty == 1'b1, "R10 still empty", empty, 1);
    push(8'hA5);
    check(empty == 1'b0, "R10 one byte after ignored pop", empty, 0);
    check(head_data == 8'hA5, "R1 fall-through head", head_data, 8'hA5);
    pop_one();
    check(empty == 1'b1, "R1 empty after drain", empty, 1);

    // R2 flow characters are data
    n0 = got_tx.size();
    push(8'h11); push(8'h13); push(8'h00); push(8'hFF); push(8'h13);
    idle_cycles(6);
    check(got_tx.size() == n0 && !tx_req, "R2 no request from data", got_tx.size(), n0);
    repeat (5) pop_one();

    // R3 / R5 / R4 thresholds
    n0 = got_tx.size();
    for (int i = 0; i < 95; i++) push(8'(i) ^ 8'h3C);
    idle_cycles(6);
    check(got_tx.size() == n0, "R3 no pause at 95", got_tx.size(), n0);
    push(8'hC3);
    @(negedge clk);
    check(tx_req == 1'b1 && tx_char == 8'h13, "R3 pause request", {tx_req, tx_char}, {1'b1, 8'h13});
    idle_cycles(6);
    check(got_tx.size() == n0 + 1 && got_tx[got_tx.size()-1] == 8'h13, "R3 pause sent",
          got_tx[got_tx.size()-1], 8'h13);
    for (int i = 0; i < 4; i++) push(8'h50 + 8'(i));
    idle_cycles(6);
    check(got_tx.size() == n0 + 1, "R5 single pause", got_tx.size(), n0 + 1);
    repeat (68) pop_one();
    idle_cycles(6);
    check(got_tx.size() == n0 + 1, "R4 no resume at 32", got_tx.size(), n0 + 1);
    pop_one();
    @(negedge clk);
    check(tx_req == 1'b1 && tx_char == 8'h11, "R4 resume request", {tx_req, tx_char}, {1'b1, 8'h11});
    idle_cycles(6);
    check(got_tx.size() == n0 + 2 && got_tx[got_tx.size()-1] == 8'h11, "R4 resume sent",
          got_tx[got_tx.size()-1], 8'h11);
    repeat (31) pop_one();
    check(empty == 1'b1, "R1 empty after threshold test", empty, 1);

    // R7 / R8 / R9 full buffer
    for (int i = 0; i < DEPTH; i++) push(8'(i * 7));
    check(ovf_sticky == 1'b0, "R7 no overflow at capacity", ovf_sticky, 0);
    push(8'hEE);
    check(ovf_sticky == 1'b1, "R7 overflow on drop", ovf_sticky, 1);
    ovf_clear = 1'b1; @(negedge clk); ovf_clear = 1'b0;
    check(ovf_sticky == 1'b0, "R8 cleared", ovf_sticky, 0);
    push_pop(8'h77);
    check(ovf_sticky == 1'b0, "R9 push+pop at full accepted", ovf_sticky, 0);
    push(8'h88);
    check(ovf_sticky == 1'b1, "R9 level stayed full", ovf_sticky, 1);
    ovf_clear = 1'b1; push(8'h99); ovf_clear = 1'b0;
    check(ovf_sticky == 1'b1, "R8 drop wins over clear", ovf_sticky, 1);
    ovf_clear = 1'b1; @(negedge clk); ovf_clear = 1'b0;
    n0 = got_tx.size();
    repeat (DEPTH) pop_one();
    idle_cycles(6);
    check(empty == 1'b1, "R9 drained after full", empty, 1);
    check(got_tx.size() == n0 + 1 && got_tx[got_tx.size()-1] == 8'h11, "R4 resume after drain",
          got_tx[got_tx.size()-1], 8'h11);
    push(8'h21); push(8'h22);
    push_pop(8'h23); push_pop(8'h24); push_pop(8'h25);
    pop_one();
    check(empty == 1'b0, "R9 level kept at partial fill", empty, 0);
    pop_one();
    check(empty == 1'b1, "R9 level 2 after swaps", empty, 1);

    // R11 timeout
    push(8'h42);
    first = -1; pulses = 0;
    for (int k = 1; k <= IDLE + 20; k++) begin
      @(negedge clk);
      if (parser_reset) begin
        pulses++;
        if (first < 0) first = k;
      end
    end
    check(first == IDLE, "R11 timeout cycle", first, IDLE);
    check(pulses == 1, "R11 single pulse", pulses, 1);
    pop_one();

    // R12 restart on each byte
    pulses = 0;
    for (int r = 0; r < 4; r++) begin
      push(8'h60 + 8'(r));
      for (int k = 0; k < IDLE - 10; k++) begin
        @(negedge clk);
        if (parser_reset) pulses++;
      end
    end
    check(pulses == 0, "R12 no timeout with steady bytes", pulses, 0);
    repeat (4) pop_one();
    check(empty == 1'b1 && exp_q.size() == 0, "R1 all compared", exp_q.size(), 0);

    finish_run();
  end
endmodule